// File: doc/BRIEF.md
# Multi-Mode Pattern Generator

This block drives an 8-bit output bus with one of eight selectable patterns. Three of the patterns are free-running sequences: a binary up-counter, a single one bit that rotates, and an 8-bit linear feedback shift register. The other patterns are combinational functions of the inputs. They either hold a stored byte, invert it, pass the probe bus straight through, or XOR the probe bus with the stored byte.

The sequences advance at a rate set by a programmable update divider. The selection and configuration values come in as plain inputs from registers that sit elsewhere in the chip. The three sequence states keep running whichever mode is selected. When a sequence mode is selected, the output therefore shows wherever that sequence has reached at that moment.

Top module: `pgen_top`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, the counter state is 0x00, the walking-one state is 0x01, the LFSR state is 0x01 and the divider count is 0. The output shows the matching value for the selected mode.
- R2: Mode 0 drives `patA` on the output.
- R3: Mode 1 drives a counter that adds 1 on each advance and wraps from 0xFF to 0x00.
- R4: Mode 2 drives a one-hot value that rotates left by one bit on each advance and wraps from bit 7 to bit 0.
- R5: Mode 3 drives an LFSR whose next state is {s[6:0], s[7]^s[5]^s[4]^s[3]} (polynomial x^8+x^6+x^5+x^4+1). A zero state loads 0x01. Starting from 0x01, the output is never zero and repeats every 255 advances.
- R6: Mode 4 drives the bitwise inverse of `patA`.
- R7: Mode 5 drives `probe` unchanged.
- R8: Modes 6 and 7 both drive `probe ^ patA`.
- R9: With divider value N, the sequences advance once every N+1 clocks. The first advance after reset is released happens on the (N+1)th rising edge. N=0 advances on every edge.
- R10: Bits 7:6 of `divIn` have no effect; only bits 5:0 set N.
- R11: The three sequences keep advancing while any other mode is selected.
- R12: In modes 0 and 4 to 7, the output follows its inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 3 | Pattern mode select |
| divIn | input | 8 | Update divider; bits 5:0 used |
| patA | input | 8 | Stored pattern byte |
| probe | input | 8 | Probe bus |
| patOut | output | 8 | Generated pattern |

## Verification
The checker tests several rules on every cycle:
- the held and XOR modes against their inputs;
- the one-hot shape of the walking bit and the absence of zero in the LFSR output;
- counter increments and holds relative to the divider strobe;
- the rule that a strobe with a nonzero divider cannot be followed directly by another.

Only the bench scenarios can show the other behaviours:
- the exact advance period and the first-advance cycle after reset;
- the LFSR period of 255 and the counter and walking-one wraps;
- that the divider's upper bits are ignored and the sequences keep running while another mode is shown.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD  = 3'd0,
    SEL_CNT   = 3'd1,
    SEL_WALK  = 3'd2,
    SEL_LFSR  = 3'd3,
    SEL_INV   = 3'd4,
    SEL_PROBE = 3'd5,
    SEL_XOR   = 3'd6
  } patSel_e;

  typedef struct packed {
    logic    stepSeq;
    patSel_e sel;
  } pgenStrobe_t;
endpackage

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
#(
  parameter int MODE_W   = 3,
  parameter int DIV_IN_W = 8,
  parameter int DIV_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modeIn,
  input  logic [DIV_IN_W-1:0] divIn,
  output pgenStrobe_t         strb
);
  logic [DIV_W-1:0] divLim;
  logic [DIV_W-1:0] divCnt;
  logic             reachLim;

  assign divLim   = divIn[DIV_W-1:0];
  assign reachLim = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (reachLim) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb.stepSeq = reachLim;
    case (modeIn)
      3'd0:    strb.sel = SEL_HOLD;
      3'd1:    strb.sel = SEL_CNT;
      3'd2:    strb.sel = SEL_WALK;
      3'd3:    strb.sel = SEL_LFSR;
      3'd4:    strb.sel = SEL_INV;
      3'd5:    strb.sel = SEL_PROBE;
      default: strb.sel = SEL_XOR;
    endcase
  end
endmodule

// File: rtl/pgen_datapath.sv
module pgen_datapath
  import pgen_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] TAP_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgenStrobe_t       strb,
  input  logic [DATA_W-1:0] patA,
  input  logic [DATA_W-1:0] probe,
  output logic [DATA_W-1:0] patOut
);
  localparam logic [DATA_W-1:0] ONE_HOT0 = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] cntQ, walkQ, lfsrQ;
  logic [DATA_W-1:0] lfsrNext;

  always_comb begin
    if (lfsrQ == '0) begin
      lfsrNext = ONE_HOT0;
    end else begin
      lfsrNext = {lfsrQ[DATA_W-2:0], ^(lfsrQ & TAP_MASK)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      walkQ <= ONE_HOT0;
      lfsrQ <= ONE_HOT0;
    end else if (strb.stepSeq) begin
      cntQ  <= cntQ + 1'b1;
      walkQ <= {walkQ[DATA_W-2:0], walkQ[DATA_W-1]};
      lfsrQ <= lfsrNext;
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_HOLD:  patOut = patA;
      SEL_CNT:   patOut = cntQ;
      SEL_WALK:  patOut = walkQ;
      SEL_LFSR:  patOut = lfsrQ;
      SEL_INV:   patOut = ~patA;
      SEL_PROBE: patOut = probe;
      default:   patOut = probe ^ patA;
    endcase
  end
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MODE_W   = 3,
  parameter int DIV_IN_W = 8,
  parameter int DIV_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modeIn,
  input  logic [DIV_IN_W-1:0] divIn,
  input  logic [DATA_W-1:0]   patA,
  input  logic [DATA_W-1:0]   probe,
  output logic [DATA_W-1:0]   patOut
);
  pgenStrobe_t strb;

  pgen_ctrl #(
    .MODE_W(MODE_W), .DIV_IN_W(DIV_IN_W), .DIV_W(DIV_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .divIn(divIn), .strb(strb)
  );

  pgen_datapath #(
    .DATA_W(DATA_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .patA(patA), .probe(probe),
    .patOut(patOut)
  );
endmodule

// File: rtl/pgen_chk.sv
module pgen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeIn,
  input logic [7:0]        divIn,
  input logic [DATA_W-1:0] patA,
  input logic [DATA_W-1:0] probe,
  input logic [DATA_W-1:0] patOut,
  input logic              stepSeq
);
  // R2
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd0) |-> (patOut == patA));

  // R8
  xor_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn[2:1] == 2'b11) |-> (patOut == (probe ^ patA)));

  // R4
  walk_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd2) |-> ($countones(patOut) == 1));

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd3) |-> (patOut != '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepSeq && modeIn == 3'd1) |=>
      (modeIn != 3'd1 || patOut == $past(patOut) + 1'b1));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepSeq && modeIn == 3'd1) |=> (modeIn != 3'd1 || $stable(patOut)));

  // R9
  div_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepSeq && divIn[5:0] != 6'd0) |=> (!stepSeq || divIn[5:0] == 6'd0));
endmodule

bind pgen_top pgen_chk #(.DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .modeIn(modeIn), .divIn(divIn), .patA(patA),
  .probe(probe), .patOut(patOut), .stepSeq(strb.stepSeq)
);

// File: tb/pgen_top_tb_top.sv
`timescale 1ns/1ps
module pgen_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeIn = 3'd0;
  logic [7:0] divIn = 8'd0;
  logic [7:0] patA = 8'd0;
  logic [7:0] probe = 8'd0;
  logic [7:0] patOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbQ[$];
  event sampleEv;

  // reference state, built from the requirements
  logic [7:0] mCnt, mWalk, mLfsr;
  int         mDiv;

  always #4 clk = ~clk;

  pgen_top dut_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .divIn(divIn),
    .patA(patA), .probe(probe), .patOut(patOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 8'h00; mWalk <= 8'h01; mLfsr <= 8'h01; mDiv <= 0;
    end else if (mDiv >= int'(divIn[5:0])) begin
      mDiv  <= 0;
      mCnt  <= mCnt + 8'd1;
      mWalk <= {mWalk[6:0], mWalk[7]};
      mLfsr <= (mLfsr == 8'h00) ? 8'h01 :
               {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
    end else begin
      mDiv <= mDiv + 1;
    end
  end

  function automatic logic [7:0] modelOut();
    case (modeIn)
      3'd0: return patA;
      3'd1: return mCnt;
      3'd2: return mWalk;
      3'd3: return mLfsr;
      3'd4: return ~patA;
      3'd5: return probe;
      default: return probe ^ patA;
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        nChecks++;
        if (patOut !== it.exp) begin
          nFail++;
          $display("FAIL %s: patOut=%02h expected=%02h", it.tag, patOut, it.exp);
        end
      end
    end
  end

  task automatic pushExp(input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    ->sampleEv;
    #0.1;
  endtask

  // drive at the falling edge, check 1 ns later against the model
  task automatic drive(input logic [2:0] m, input logic [7:0] d,
                       input logic [7:0] a, input logic [7:0] p, input string tag);
    @(negedge clk);
    modeIn = m; divIn = d; patA = a; probe = p;
    #1;
    pushExp(modelOut(), tag);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: expired, expected run end");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsrStart;
    // R1 reset values
    drive(3'd1, 8'd3, 8'h5A, 8'h00, "R1");
    pushExp(8'h00, "R1");
    drive(3'd2, 8'd3, 8'h5A, 8'h00, "R1");
    pushExp(8'h01, "R1");
    drive(3'd3, 8'd3, 8'h5A, 8'h00, "R1");
    pushExp(8'h01, "R1");
    drive(3'd0, 8'd3, 8'h5A, 8'h00, "R1");
    pushExp(8'h5A, "R1");
    modeIn = 3'd1;
    @(negedge clk);
    rstN = 1'b1;
    // R9: at falling edge k after release, counter = k/4 for N=3
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      #1;
      pushExp(8'(k / 4), "R9");
    end
    for (int i = 0; i < 10; i++) drive(3'd1, 8'd5, 8'h00, 8'h00, "R9");
    // R2 / R6 / R7 / R8
    drive(3'd0, 8'd0, 8'hC3, 8'h00, "R2");
    drive(3'd0, 8'd0, 8'h00, 8'hFF, "R2");
    drive(3'd4, 8'd0, 8'hC3, 8'h00, "R6");
    pushExp(8'h3C, "R6");
    drive(3'd4, 8'd0, 8'h00, 8'h00, "R6");
    drive(3'd5, 8'd0, 8'hFF, 8'hA5, "R7");
    pushExp(8'hA5, "R7");
    drive(3'd6, 8'd0, 8'h0F, 8'hA5, "R8");
    pushExp(8'hAA, "R8");
    drive(3'd7, 8'd0, 8'h0F, 8'hA5, "R8");
    pushExp(8'hAA, "R8");
    drive(3'd7, 8'd0, 8'hFF, 8'h00, "R8");
    // R12: change probe twice within one low phase
    @(negedge clk);
    modeIn = 3'd5; probe = 8'h12;
    #1; pushExp(8'h12, "R12");
    probe = 8'h34;
    #1; pushExp(8'h34, "R12");
    modeIn = 3'd4; patA = 8'hF0;
    #1; pushExp(8'h0F, "R12");
    // R3 counter wrap at divider 0
    for (int i = 0; i < 300; i++) drive(3'd1, 8'd0, 8'h00, 8'h00, "R3");
    // R4 walking one wrap
    for (int i = 0; i < 20; i++) drive(3'd2, 8'd0, 8'h00, 8'h00, "R4");
    // R5 LFSR run and period
    drive(3'd3, 8'd0, 8'h00, 8'h00, "R5");
    lfsrStart = patOut;
    for (int i = 0; i < 254; i++) drive(3'd3, 8'd0, 8'h00, 8'h00, "R5");
    drive(3'd3, 8'd0, 8'h00, 8'h00, "R5");
    pushExp(lfsrStart, "R5");
    // R11 sequences run while another mode is shown
    for (int i = 0; i < 7; i++) drive(3'd0, 8'd2, 8'h77, 8'h00, "R11");
    drive(3'd1, 8'd2, 8'h00, 8'h00, "R11");
    drive(3'd2, 8'd2, 8'h00, 8'h00, "R11");
    drive(3'd3, 8'd2, 8'h00, 8'h00, "R11");
    // R10 upper divider bits ignored: 0xC0 acts as 0, 0x43 acts as 3
    for (int i = 0; i < 12; i++) drive(3'd1, 8'hC0, 8'h00, 8'h00, "R10");
    for (int i = 0; i < 12; i++) drive(3'd1, 8'h43, 8'h00, 8'h00, "R10");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule